// File: doc/BRIEF.md
# I2C Register-Bank Slave with Strapped Address

This block is the host-facing serial front end of a sensor-style subsystem. A host on a two-wire I2C bus reads and writes a small byte-wide register map through it. The slave's 7-bit bus address comes from a three-level strap. The strap is captured once, when reset is released, so the bus address stays fixed for the whole powered session. SCL and SDA arrive as plain inputs and pass through a two-flop synchroniser. SDA is driven only as an open-drain pull-down enable.

Every transfer goes through one 8-bit register pointer. A write transfer first loads the pointer and then stores data bytes, and the pointer advances after each byte. A read transfer sends no pointer byte: it streams bytes from wherever the pointer currently stands and advances it as it goes. The lower registers are read-write configuration bytes, and the chip sees them in parallel on `cfgOut`. Above them sit a 16-bit measurement value, loaded from the chip, and a fixed 16-bit identifier. Both are read-only. A key value placed in the software-reset register acts when the transfer ends with STOP: it pulses a reset to the measurement logic and clears the measurement value.

Top module: `strap_i2c_regbank`

## Requirements
- R1: The strap `addrStrap` is {pulled-high, pulled-low}. 2'b10 selects bus address 0x29, 2'b01 selects 0x49, and 2'b00 (floating) or 2'b11 selects 0x39.
- R2: The strap is captured in the first clock after reset is released. Later strap changes do not alter the address until the next reset.
- R3: An address byte that does not match is not acknowledged. The slave then keeps SDA released until the next START.
- R4: A write is START, address with R/W=0, a pointer byte, then any number of data bytes. Each byte is acknowledged. A data byte aimed at pointer 0..NUM_CFG-1 is stored into that configuration byte, which appears at `cfgOut[8*p +: 8]`. The pointer then increments (mod 256).
- R5: A read (address with R/W=1) sends bytes MSB first, starting at the current pointer. After each byte the pointer increments. The slave sends the next byte only while the master acknowledges. A master NACK ends the transfer.
- R6: A data byte written to a read-only or unimplemented pointer is acknowledged and discarded. The pointer still advances.
- R7: If register 1 holds 0x30 when a STOP is detected, `measReset` pulses for one cycle. The measurement value clears to 0x0000 and register 1 returns to 0x00. The other configuration bytes keep their values.
- R8: A write may end with a repeated START instead of STOP. No reset action happens at a repeated START. A read that follows starts at the pointer the write left.
- R9: Pointers NUM_CFG and NUM_CFG+1 read the low and high byte of the measurement value. NUM_CFG+2 and NUM_CFG+3 read the low and high byte of DEV_ID. Every higher pointer reads 0x00.
- R10: The slave changes `sdaOe` only while SCL is low.
- R11: After reset, `sdaOe` is 0, all configuration bytes are 0x00 and the measurement value is 0x0000.
- R12: A `measLoad` pulse copies `measData` into the measurement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock level as seen at the pad |
| sdaIn | input | 1 | Bus data level as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| addrStrap | input | 2 | Strap sense {pulled-high, pulled-low} |
| measData | input | 16 | New measurement value from the chip |
| measLoad | input | 1 | Capture strobe for measData |
| measReset | output | 1 | One-cycle reset pulse to the measurement logic |
| cfgOut | output | 8*NUM_CFG | Configuration bytes, byte p at [8p+7:8p] |

## Verification
The assertions take for granted that the master changes SDA only while SCL is low, except for START and STOP. They also assume each SCL phase lasts several system clocks, so the slave's reaction after the synchroniser lands inside the same low phase. They further assume the master never issues STOP while the slave is pulling SDA low. The bench master keeps every quarter bit at five clocks and drives SDA only in the low half. It releases SDA before it requests an acknowledge or a slave bit. Random pointers, burst lengths and data stay within legal transfers that complete cleanly.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_MACK
  } busState_t;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic shiftIn;   // sample one received bit
    logic setPtr;    // received byte becomes the pointer
    logic writeReg;  // store received byte at pointer
    logic incPtr;    // advance pointer
    logic loadTx;    // load transmit byte from pointer
    logic shiftTx;   // move to next transmit bit
    logic stopSeen;  // STOP condition detected
  } strobes_t;

endpackage

// File: rtl/strap_i2c_ctl.sv
module strap_i2c_ctl
  import strap_i2c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      rdMsb,
  input  logic      txNext,
  output strobes_t  stb,
  output logic      sdaBit,
  output logic      sdaOe,
  output busState_t busState
);

  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD;
  logic       sclS, sdaS;
  logic       startDet, stopDet, sclRise, sclFall;
  logic [3:0] bitCnt;
  logic       isRead;
  logic       ackSeen;
  busState_t  state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign sdaBit   = sdaS;
  assign busState = state;

  always_comb begin
    stb = '0;
    stb.stopSeen = stopDet;
    if (!startDet && !stopDet) begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) stb.shiftIn = 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_PTR)   stb.setPtr = 1'b1;
            if (state == ST_WDATA) begin
              stb.writeReg = 1'b1;
              stb.incPtr   = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall && isRead) stb.loadTx = 1'b1;
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) stb.incPtr  = 1'b1;
            else                stb.shiftTx = 1'b1;
          end
        end
        ST_MACK: if (sclFall && ackSeen) stb.loadTx = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      sdaOe   <= 1'b0;
      isRead  <= 1'b0;
      ackSeen <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (sclFall && bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrHit) begin
                state  <= ST_ADDR_ACK;
                sdaOe  <= 1'b1;
                isRead <= rwBit;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= (state == ST_PTR) ? ST_PTR_ACK : ST_WDATA_ACK;
              sdaOe <= 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              state <= ST_RDATA;
              sdaOe <= ~rdMsb;
            end else begin
              state <= ST_PTR;
              sdaOe <= 1'b0;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            state  <= ST_WDATA;
            bitCnt <= '0;
            sdaOe  <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state  <= ST_MACK;
              bitCnt <= '0;
              sdaOe  <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 4'd1;
              sdaOe  <= ~txNext;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) ackSeen <= ~sdaS;
          if (sclFall) begin
            if (ackSeen) begin
              state  <= ST_RDATA;
              bitCnt <= '0;
              sdaOe  <= ~rdMsb;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strap_i2c_regs.sv
module strap_i2c_regs
  import strap_i2c_pkg::*;
#(
  parameter int          NUM_CFG  = 6,
  parameter logic [15:0] DEV_ID   = 16'h5A3C,
  parameter logic [6:0]  ADDR_HI  = 7'h29,
  parameter logic [6:0]  ADDR_FLT = 7'h39,
  parameter logic [6:0]  ADDR_LO  = 7'h49,
  parameter logic [7:0]  RST_KEY  = 8'h30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           addrStrap,
  input  strobes_t             stb,
  input  logic                 sdaBit,
  input  logic [15:0]          measData,
  input  logic                 measLoad,
  output logic                 addrHit,
  output logic                 rwBit,
  output logic                 rdMsb,
  output logic                 txNext,
  output logic [8*NUM_CFG-1:0] cfgOut,
  output logic                 measReset,
  output logic [6:0]           myAddr,
  output logic                 strapDone
);

  localparam int          RST_IDX = 1;
  localparam logic [7:0]  DATA_LO = 8'(NUM_CFG);
  localparam logic [7:0]  DATA_HI = 8'(NUM_CFG + 1);
  localparam logic [7:0]  ID_LO   = 8'(NUM_CFG + 2);
  localparam logic [7:0]  ID_HI   = 8'(NUM_CFG + 3);

  logic [1:0]  strapQ;
  logic [7:0]  rxShift, txShift, ptr, readByte;
  logic [15:0] measVal;
  logic [7:0]  cfgR [NUM_CFG];
  logic        fireRst;

  // strap captured once after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ    <= 2'b00;
      strapDone <= 1'b0;
    end else if (!strapDone) begin
      strapQ    <= addrStrap;
      strapDone <= 1'b1;
    end
  end

  always_comb begin
    unique case (strapQ)
      2'b10:   myAddr = ADDR_HI;
      2'b01:   myAddr = ADDR_LO;
      default: myAddr = ADDR_FLT;
    endcase
  end

  assign addrHit = (rxShift[7:1] == myAddr);
  assign rwBit   = rxShift[0];
  assign fireRst = stb.stopSeen && (cfgR[RST_IDX] == RST_KEY);

  generate
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               cfgR[g] <= '0;
        else if (g == RST_IDX && fireRst)        cfgR[g] <= '0;
        else if (stb.writeReg && ptr == 8'(g))   cfgR[g] <= rxShift;
      end
      assign cfgOut[8*g +: 8] = cfgR[g];
    end
  endgenerate

  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (ptr == 8'(i)) readByte = cfgR[i];
    if (ptr == DATA_LO) readByte = measVal[7:0];
    if (ptr == DATA_HI) readByte = measVal[15:8];
    if (ptr == ID_LO)   readByte = DEV_ID[7:0];
    if (ptr == ID_HI)   readByte = DEV_ID[15:8];
  end

  assign rdMsb  = readByte[7];
  assign txNext = txShift[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      ptr       <= '0;
      measVal   <= '0;
      measReset <= 1'b0;
    end else begin
      measReset <= fireRst;
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (stb.setPtr)       ptr <= rxShift;
      else if (stb.incPtr)  ptr <= ptr + 8'd1;
      if (stb.loadTx)       txShift <= readByte;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (fireRst)          measVal <= '0;
      else if (measLoad)    measVal <= measData;
    end
  end

endmodule

// File: rtl/strap_i2c_regbank.sv
module strap_i2c_regbank
  import strap_i2c_pkg::*;
#(
  parameter int          NUM_CFG = 6,
  parameter logic [15:0] DEV_ID  = 16'h5A3C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  input  logic [1:0]           addrStrap,
  input  logic [15:0]          measData,
  input  logic                 measLoad,
  output logic                 measReset,
  output logic [8*NUM_CFG-1:0] cfgOut
);

  strobes_t   stb;
  busState_t  busState;
  logic       addrHit, rwBit, rdMsb, txNext, sdaBit, strapDone;
  logic [6:0] myAddr;

  strap_i2c_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .rwBit(rwBit), .rdMsb(rdMsb), .txNext(txNext),
    .stb(stb), .sdaBit(sdaBit), .sdaOe(sdaOe), .busState(busState)
  );

  strap_i2c_regs #(.NUM_CFG(NUM_CFG), .DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap), .stb(stb),
    .sdaBit(sdaBit), .measData(measData), .measLoad(measLoad),
    .addrHit(addrHit), .rwBit(rwBit), .rdMsb(rdMsb), .txNext(txNext),
    .cfgOut(cfgOut), .measReset(measReset), .myAddr(myAddr),
    .strapDone(strapDone)
  );

endmodule

// File: rtl/strap_i2c_regbank_chk.sv
module strap_i2c_regbank_chk
  import strap_i2c_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       measReset,
  input logic [7:0] rstByte,
  input busState_t  busState,
  input logic [6:0] myAddr,
  input logic       strapDone
);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strapDone && $past(strapDone)) |-> $stable(myAddr));

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> !sdaOe);

  p_reset_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    measReset |=> !measReset);

  p_reset_clears_key_r7: assert property (@(posedge clk) disable iff (!rstN)
    measReset |-> (rstByte == 8'h00));

endmodule

bind strap_i2c_regbank strap_i2c_regbank_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .measReset(measReset), .rstByte(cfgOut[15:8]), .busState(busState),
  .myAddr(myAddr), .strapDone(strapDone)
);

// File: tb/strap_i2c_regbank_tb.sv
module strap_i2c_regbank_tb;

  localparam int NCFG = 6;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  logic [1:0] addrStrap = 2'b10;
  logic [15:0] measData = '0;
  logic measLoad = 1'b0;
  logic measReset;
  logic [8*NCFG-1:0] cfgOut;
  wire  sdaLine = mSda & ~sdaOe;

  int total = 0, bad = 0, pulses = 0, expPulses = 0;
  logic [7:0]  mdl [NCFG];
  logic [15:0] dataM;
  logic [7:0]  ptrM;
  logic [6:0]  addrE;

  always #2 clk = ~clk;

  strap_i2c_regbank #(.NUM_CFG(NCFG), .DEV_ID(16'h5A3C)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrStrap(addrStrap), .measData(measData), .measLoad(measLoad),
    .measReset(measReset), .cfgOut(cfgOut)
  );

  always @(posedge clk) if (rstN && measReset) pulses++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [7:0] p);
    if (p < 8'(NCFG)) return mdl[p];
    if (p == 8'd6) return dataM[7:0];
    if (p == 8'd7) return dataM[15:8];
    if (p == 8'd8) return 8'h3C;
    if (p == 8'd9) return 8'h5A;
    return 8'h00;
  endfunction

  function automatic logic [8*NCFG-1:0] expCfg();
    logic [8*NCFG-1:0] v;
    for (int i = 0; i < NCFG; i++) v[8*i +: 8] = mdl[i];
    return v;
  endfunction

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ();
    if (mdl[1] == 8'h30) begin mdl[1] = 8'h00; dataM = '0; expPulses++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); ack = ~sdaLine; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); mScl = 1'b1; waitQ(); b[i] = sdaLine; waitQ(); mScl = 1'b0;
    end
    mSda = ~ackIt; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ(); mSda = 1'b1;
  endtask

  task automatic doReset(input logic [1:0] strap);
    rstN = 1'b0; addrStrap = strap; repeat (4) @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NCFG; i++) mdl[i] = 8'h00;
    dataM = '0; ptrM = '0;
    addrE = (strap == 2'b10) ? 7'h29 : (strap == 2'b01) ? 7'h49 : 7'h39;
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    startCond(); sendByte({a, 1'b0}, ack); stopCond();
  endtask

  // write pointer plus n data bytes; ends with STOP when doStop
  task automatic xferWrite(input logic [7:0] p, input int n,
                           input logic [31:0] bytes, input bit doStop);
    logic ack; int nak = 0;
    startCond();
    sendByte({addrE, 1'b0}, ack); if (!ack) nak++;
    sendByte(p, ack); if (!ack) nak++;
    ptrM = p;
    for (int i = 0; i < n; i++) begin
      sendByte(bytes[8*i +: 8], ack); if (!ack) nak++;
      if (ptrM < 8'(NCFG)) mdl[ptrM] = bytes[8*i +: 8];
      ptrM = ptrM + 8'd1;
    end
    check("R4 acks on write", 64'(nak), 64'd0);
    if (doStop) stopCond();
  endtask

  task automatic xferRead(input int n, input string req);
    logic ack; logic [7:0] b;
    startCond();
    sendByte({addrE, 1'b1}, ack);
    check({req, " read address ack"}, 64'(ack), 64'd1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      check(req, 64'(b), 64'(expByte(ptrM)));
      ptrM = ptrM + 8'd1;
    end
    stopCond();
  endtask

  task automatic loadMeas(input logic [15:0] v);
    measData = v; measLoad = 1'b1; @(negedge clk); measLoad = 1'b0; dataM = v;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'd4242));
    doReset(2'b10);
    // R11: reset state
    check("R11 sdaOe after reset", 64'(sdaOe), 64'd0);
    check("R11 cfg after reset", 64'(cfgOut), 64'd0);

    // R1 / R3: strap high gives 0x29, others not acked
    probe(7'h39, ack); check("R3 foreign address nack", 64'(ack), 64'd0);
    check("R3 released after nack", 64'(sdaOe), 64'd0);
    probe(7'h29, ack); check("R1 strap high address", 64'(ack), 64'd1);
    // R2: later strap change ignored
    addrStrap = 2'b01; repeat (5) @(negedge clk);
    probe(7'h29, ack); check("R2 address held", 64'(ack), 64'd1);
    probe(7'h49, ack); check("R2 new strap ignored", 64'(ack), 64'd0);

    // R4: burst writes
    xferWrite(8'd0, 2, 32'h0000_2211, 1'b1);
    xferWrite(8'd2, 4, 32'hA4A3_A2A1, 1'b1);
    check("R4 cfg bytes", 64'(cfgOut), 64'(expCfg()));

    // R12 + R5 + R9: measurement and id, burst read
    loadMeas(16'hBEEF);
    xferWrite(8'd6, 0, 32'h0, 1'b1);
    xferRead(4, "R12 R5 meas/id burst");
    xferRead(2, "R9 past map reads zero");
    xferWrite(8'hFF, 0, 32'h0, 1'b1);
    xferRead(2, "R9 pointer wrap");

    // R5: read with no pointer byte continues from pointer
    xferWrite(8'd3, 0, 32'h0, 1'b1);
    xferRead(1, "R5 read at pointer");
    xferRead(2, "R5 read continues");

    // R6: write to read-only register discarded, pointer advances
    xferWrite(8'd6, 1, 32'h55, 1'b1);
    xferRead(1, "R6 pointer advanced past read-only");
    xferWrite(8'd6, 0, 32'h0, 1'b1);
    xferRead(2, "R6 read-only unchanged");

    // R8: repeated start after write, read from left pointer
    xferWrite(8'd4, 1, 32'h77, 1'b0);
    xferRead(1, "R8 read after repeated start");
    check("R8 cfg after repeated start", 64'(cfgOut), 64'(expCfg()));

    // R7: reset key only acts at STOP
    xferWrite(8'd1, 1, 32'h30, 1'b0);
    check("R7 no reset at repeated start", 64'(pulses), 64'(expPulses));
    check("R7 key held before stop", 64'(cfgOut[15:8]), 64'h30);
    xferRead(1, "R7 read then stop");
    check("R7 reset pulse at stop", 64'(pulses), 64'(expPulses));
    check("R7 key cleared others kept", 64'(cfgOut), 64'(expCfg()));
    xferWrite(8'd6, 0, 32'h0, 1'b1);
    xferRead(2, "R7 measurement cleared");
    xferWrite(8'd1, 1, 32'h31, 1'b1);
    check("R7 other value no reset", 64'(pulses), 64'(expPulses));
    check("R7 other value stored", 64'(cfgOut[15:8]), 64'h31);

    // random bursts against the model
    for (int it = 0; it < 24; it++) begin
      int n; logic [7:0] p;
      n = 1 + int'($urandom % 3);
      p = 8'($urandom % 12);
      if (($urandom % 4) == 0) loadMeas(16'($urandom));
      xferWrite(p, n, $urandom, 1'b1);
      check("R4 random cfg", 64'(cfgOut), 64'(expCfg()));
      check("R7 random pulses", 64'(pulses), 64'(expPulses));
      xferWrite(8'($urandom % 12), 0, 32'h0, 1'b1);
      xferRead(1 + int'($urandom % 4), "R5 random read");
    end

    // R1: the other strap values after fresh resets
    doReset(2'b01);
    check("R11 cfg cleared by reset", 64'(cfgOut), 64'd0);
    probe(7'h49, ack); check("R1 strap low address", 64'(ack), 64'd1);
    doReset(2'b00);
    probe(7'h39, ack); check("R1 strap float address", 64'(ack), 64'd1);
    probe(7'h29, ack); check("R3 old address after resample", 64'(ack), 64'd0);
    doReset(2'b11);
    probe(7'h39, ack); check("R1 strap both address", 64'(ack), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule